// File: doc/BRIEF.md
# POST Code History Capture

This block listens passively on an LPC bus during board power-up. It picks out I/O write cycles aimed at one diagnostic port, which is 0x80 by default, and treats the data byte of each such cycle as a power-on self-test progress code. The last five codes are kept in a small history. When a boot fails, the trail of progress codes leading up to the failure is still there to inspect.

A management controller reads the history through a simple indexed port. It places an index on `rd_idx`, and one clock later `rd_code` holds the code stored at that position. Index 0 is the newest code and index 4 the oldest. `rd_hit` shows whether that slot holds a real code. The live number of stored codes is always visible on `valid_count`, so an empty slot cannot be mistaken for a genuine code of 0x00. A synchronous `clr` pulse empties the history at the start of each power-up attempt.

Top module: `post_code_capture`

## Requirements
- R1: After reset, `valid_count` is 0 and any read returns `rd_hit`=0 with `rd_code`=0x00.
- R2: A complete LPC I/O write to the configured port (default 0x0080) stores its data byte at index 0 and raises `valid_count` by one, at the latest two clocks after the last data nibble.
- R3: I/O writes to any other 16-bit address leave the history and `valid_count` unchanged.
- R4: Only a cycle-type nibble matching 001x (I/O write) is accepted; I/O reads (0000) and memory writes (0110) are ignored.
- R5: The address is taken as four nibbles, most significant first. The data is taken as two nibbles, low nibble first.
- R6: Each new code moves older codes one index up. Once five codes are held, the oldest is dropped and `valid_count` stays at 5.
- R7: A cycle is accepted only if its start nibble (the last `lframe_n`-low clock) is 0000. Driving `lframe_n` low in the middle of a cycle abandons that cycle.
- R8: A `clr` pulse sets `valid_count` to 0 and makes every slot read back as a miss with code 0x00.
- R9: A read at an index equal to or beyond `valid_count`, including 5 to 7, returns `rd_hit`=0 and `rd_code`=0x00.
- R10: Read data appears one clock after `rd_idx` is applied. Reads never change the stored history.
- R11: If `clr` arrives in the same clock as a capture, the clear wins and the history ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock; all logic is clocked on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous history clear, one clock wide |
| lframe_n | input | 1 | LPC frame strobe, active low |
| lad | input | 4 | LPC multiplexed address/data nibble |
| rd_idx | input | 3 | History index to read; 0 is the newest |
| rd_code | output | 8 | Code at the requested index, registered |
| rd_hit | output | 1 | Requested index holds a stored code, registered |
| valid_count | output | 3 | Number of codes currently held, 0 to 5 |

## Verification
A decoder that takes the wrong address, type or nibble order shows at the ports within two clocks of the final data nibble. Either `valid_count` moves when it should not, or index 0 reads back a byte with its halves swapped. A shift or saturation fault stays hidden until the history wraps. It then shows as a wrong code at a deep index, or as `valid_count` passing 5 on the sixth write. The bench therefore fills the history past its depth and reads every slot. A read-path fault shows one clock after `rd_idx` changes, most clearly as `rd_hit` set for an empty slot or a nonzero byte returned for a miss.

// File: rtl/postcap_pkg.sv
package postcap_pkg;

    // Nibble seen on the last frame-low clock that opens a host cycle
    localparam logic [3:0] LPC_START_NIB = 4'b0000;

    // Upper three bits of the type/direction nibble for an I/O write
    localparam logic [2:0] IO_WRITE_TYPE = 3'b001;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_TYPE,
        DEC_ADDR,
        DEC_DATA
    } dec_state_e;

    // One captured diagnostic byte handed from decoder to history
    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } post_event_t;

    function automatic logic is_io_write(input logic [3:0] nib);
        return nib[3:1] == IO_WRITE_TYPE;
    endfunction

    function automatic logic [CODE_W-1:0] join_nibbles(input logic [3:0] lo,
                                                       input logic [3:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/postcap_lpc_decode.sv
module postcap_lpc_decode
    import postcap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h0080,
    localparam int         NIB_CNT   = ADDR_W / 4,
    localparam int         NCNT_W    = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lframe_n,
    input  logic [3:0]  lad,
    output post_event_t evt
);

    dec_state_e          state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [NCNT_W-1:0]   nib_q;
    logic [3:0]          lo_q;
    logic                hi_phase_q;
    logic                port_match;

    assign port_match = (addr_q == ADDR_W'(PORT_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= DEC_IDLE;
            addr_q     <= '0;
            nib_q      <= '0;
            lo_q       <= '0;
            hi_phase_q <= 1'b0;
            evt        <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (!lframe_n) begin
                // R7: frame low (re)starts; only the start nibble arms decode
                state_q    <= (lad == LPC_START_NIB) ? DEC_TYPE : DEC_IDLE;
                nib_q      <= '0;
                hi_phase_q <= 1'b0;
            end else begin
                unique case (state_q)
                    DEC_TYPE: begin
                        // R4: only the I/O write type proceeds
                        if (is_io_write(lad)) begin
                            state_q <= DEC_ADDR;
                            nib_q   <= '0;
                        end else begin
                            state_q <= DEC_IDLE;
                        end
                    end
                    DEC_ADDR: begin
                        // R5: address nibbles arrive most significant first
                        addr_q <= {addr_q[ADDR_W-5:0], lad};
                        if (nib_q == NCNT_W'(NIB_CNT - 1)) begin
                            state_q    <= DEC_DATA;
                            hi_phase_q <= 1'b0;
                        end else begin
                            nib_q <= nib_q + NCNT_W'(1);
                        end
                    end
                    DEC_DATA: begin
                        if (!hi_phase_q) begin
                            lo_q       <= lad;
                            hi_phase_q <= 1'b1;
                        end else begin
                            state_q <= DEC_IDLE;
                            // R2 / R3: emit only for the snooped port
                            if (port_match) begin
                                evt.valid <= 1'b1;
                                evt.code  <= join_nibbles(lo_q, lad);
                            end
                        end
                    end
                    default: state_q <= DEC_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/postcap_history.sv
module postcap_history
    import postcap_pkg::*;
#(
    parameter  int DEPTH = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  post_event_t                    evt,
    output logic [DEPTH-1:0][CODE_W-1:0]   slots,
    output logic [CNT_W-1:0]               count
);

    logic wipe;
    assign wipe = rst || clr;   // R8 / R11: clear outranks capture

    // R6: index 0 takes the new byte, every other slot takes its neighbour
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wipe) begin
                slots[i] <= '0;
            end else if (evt.valid) begin
                if (i == 0) begin
                    slots[i] <= evt.code;
                end else begin
                    slots[i] <= slots[(i > 0) ? i - 1 : 0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            count <= '0;
        end else if (evt.valid && (count != CNT_W'(DEPTH))) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/postcap_reader.sv
module postcap_reader
    import postcap_pkg::*;
#(
    parameter  int DEPTH = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0][CODE_W-1:0] slots,
    input  logic [CNT_W-1:0]             count,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [CODE_W-1:0]            rd_code,
    output logic                         rd_hit
);

    logic [CODE_W-1:0] picked;
    logic              occupied;

    // R9: a slot counts only below the live count
    assign occupied = int'(rd_idx) < int'(count);

    always_comb begin
        picked = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(rd_idx) == i) begin
                picked = slots[i];
            end
        end
    end

    // R10: one register stage; nothing here feeds back to the history
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_code <= '0;
            rd_hit  <= 1'b0;
        end else begin
            rd_code <= occupied ? picked : '0;
            rd_hit  <= occupied;
        end
    end

endmodule

// File: rtl/post_code_capture.sv
module post_code_capture
    import postcap_pkg::*;
#(
    parameter  int          DEPTH     = 5,
    parameter  int          ADDR_W    = 16,
    parameter  logic [15:0] PORT_ADDR = 16'h0080,
    localparam int          IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int          CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              lframe_n,
    input  logic [3:0]        lad,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_code,
    output logic              rd_hit,
    output logic [CNT_W-1:0]  valid_count
);

    post_event_t                  cap_evt;
    logic                         cap_valid;
    logic [CODE_W-1:0]            cap_code;
    logic [DEPTH-1:0][CODE_W-1:0] hist_slots;
    logic [CNT_W-1:0]             hist_count;

    assign cap_valid   = cap_evt.valid;
    assign cap_code    = cap_evt.code;
    assign valid_count = hist_count;

    postcap_lpc_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .lframe_n (lframe_n),
        .lad      (lad),
        .evt      (cap_evt)
    );

    postcap_history #(
        .DEPTH (DEPTH)
    ) u_history (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .evt   (cap_evt),
        .slots (hist_slots),
        .count (hist_count)
    );

    postcap_reader #(
        .DEPTH (DEPTH)
    ) u_reader (
        .clk     (clk),
        .rst     (rst),
        .slots   (hist_slots),
        .count   (hist_count),
        .rd_idx  (rd_idx),
        .rd_code (rd_code),
        .rd_hit  (rd_hit)
    );

endmodule

// File: rtl/post_code_capture_chk.sv
module post_code_capture_chk #(
    parameter  int DEPTH = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr,
    input logic                    cap_valid,
    input logic [7:0]              cap_code,
    input logic [DEPTH-1:0][7:0]   slots,
    input logic [CNT_W-1:0]        count,
    input logic [IDX_W-1:0]        rd_idx,
    input logic [7:0]              rd_code,
    input logic                    rd_hit
);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && slots[0] == 8'h00));

    // R2
    capture_count_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !clr && int'(count) < DEPTH) |=> (count == $past(count) + CNT_W'(1)));

    // R2
    newest_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !clr) |=> (slots[0] == $past(cap_code)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_valid && !clr) |=> $stable(count));

    // R9
    miss_read_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_idx) >= int'(count)) |=> (!rd_hit && rd_code == 8'h00));

    if (DEPTH > 1) begin : g_shift
        // R6
        shift_order_chk: assert property (@(posedge clk) disable iff (rst)
            (cap_valid && !clr) |=> (slots[1] == $past(slots[0])));
    end

endmodule

bind post_code_capture post_code_capture_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .cap_valid (cap_valid),
    .cap_code  (cap_code),
    .slots     (hist_slots),
    .count     (hist_count),
    .rd_idx    (rd_idx),
    .rd_code   (rd_code),
    .rd_hit    (rd_hit)
);

// File: tb/post_code_capture_bench.sv
`timescale 1ns/1ps
module post_code_capture_bench;

    localparam int DEPTH = 5;
    localparam int IDX_W = 3;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr = 1'b0;
    logic             lframe_n = 1'b1;
    logic [3:0]       lad = 4'hF;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [7:0]       rd_code;
    logic             rd_hit;
    logic [CNT_W-1:0] valid_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_code [DEPTH];
    int         exp_cnt = 0;

    always #2 clk = ~clk;

    post_code_capture u_post_code_capture (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .lframe_n    (lframe_n),
        .lad         (lad),
        .rd_idx      (rd_idx),
        .rd_code     (rd_code),
        .rd_hit      (rd_hit),
        .valid_count (valid_count)
    );

    task automatic model_push(input logic [7:0] c);
        for (int i = DEPTH - 1; i > 0; i--) exp_code[i] = exp_code[i-1];
        exp_code[0] = c;
        if (exp_cnt < DEPTH) exp_cnt++;
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) exp_code[i] = 8'h00;
        exp_cnt = 0;
    endtask

    task automatic nib(input logic f, input logic [3:0] v);
        @(negedge clk);
        lframe_n = f;
        lad      = v;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nib(1'b1, 4'hF);
    endtask

    task automatic lpc_cycle(input logic [3:0] start, input logic [3:0] ctype,
                             input logic [15:0] addr, input logic [7:0] data);
        nib(1'b0, start);
        nib(1'b1, ctype);
        for (int i = 3; i >= 0; i--) nib(1'b1, addr[i*4 +: 4]);
        nib(1'b1, data[3:0]);
        nib(1'b1, data[7:4]);
        idle(4);
    endtask

    task automatic check_count(input string req);
        @(negedge clk);
        checks++;
        if (int'(valid_count) != exp_cnt) begin
            failures++;
            $display("FAIL %s valid_count actual=%0d expected=%0d", req, valid_count, exp_cnt);
        end
    endtask

    task automatic check_read(input int idx, input string req);
        logic [7:0] ec;
        logic       eh;
        eh = (idx < exp_cnt);
        ec = eh ? exp_code[idx] : 8'h00;
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rd_code !== ec || rd_hit !== eh) begin
            failures++;
            $display("FAIL %s idx=%0d actual code=%02h hit=%0b expected code=%02h hit=%0b",
                     req, idx, rd_code, rd_hit, ec, eh);
        end
    endtask

    task automatic check_all(input string req);
        check_count(req);
        for (int i = 0; i < DEPTH; i++) check_read(i, req);
    endtask

    task automatic t_reset();
        check_count("R1");
        check_read(0, "R1");
    endtask

    task automatic t_single();
        lpc_cycle(4'h0, 4'h2, 16'h0080, 8'hA5);
        model_push(8'hA5);           // R2 / R5: low nibble 5 first, then A
        check_count("R2");
        check_read(0, "R5");
    endtask

    task automatic t_other_addr();
        lpc_cycle(4'h0, 4'h2, 16'h0081, 8'h11);
        lpc_cycle(4'h0, 4'h2, 16'h8000, 8'h22);
        lpc_cycle(4'h0, 4'h2, 16'h1080, 8'h33);
        check_count("R3");
        check_read(0, "R3");
    endtask

    task automatic t_cycle_type();
        lpc_cycle(4'h0, 4'h0, 16'h0080, 8'h44);   // I/O read
        lpc_cycle(4'h0, 4'h6, 16'h0080, 8'h55);   // memory write
        lpc_cycle(4'h0, 4'h3, 16'h0080, 8'h5A);   // 001x with bit0 set: accepted
        model_push(8'h5A);
        check_count("R4");
        check_read(0, "R4");
    endtask

    task automatic t_abort();
        lpc_cycle(4'h5, 4'h2, 16'h0080, 8'h66);   // bad start nibble
        nib(1'b0, 4'h0);
        nib(1'b1, 4'h2);
        nib(1'b1, 4'h0);
        nib(1'b1, 4'h0);
        nib(1'b0, 4'hF);                          // frame drops mid-address
        nib(1'b1, 4'h8);
        nib(1'b1, 4'h0);
        nib(1'b1, 4'h7);
        nib(1'b1, 4'h7);
        idle(4);
        check_count("R7");
        check_read(0, "R7");
        lpc_cycle(4'h0, 4'h2, 16'h0080, 8'hC3);   // recovers on the next cycle
        model_push(8'hC3);
        check_read(0, "R7");
    endtask

    task automatic t_fill();
        for (int k = 1; k <= 5; k++) begin
            lpc_cycle(4'h0, 4'h2, 16'h0080, 8'(k));
            model_push(8'(k));
        end
        check_all("R6");
        lpc_cycle(4'h0, 4'h2, 16'h0080, 8'h00);
        model_push(8'h00);
        check_all("R6");
    endtask

    task automatic t_reads_passive();
        for (int i = 0; i < 8; i++) check_read(i, "R10");
        check_all("R10");
    endtask

    task automatic t_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_clear();
        check_all("R8");
    endtask

    task automatic t_range();
        lpc_cycle(4'h0, 4'h2, 16'h0080, 8'h7E);
        model_push(8'h7E);
        lpc_cycle(4'h0, 4'h2, 16'h0080, 8'h81);
        model_push(8'h81);
        check_read(1, "R9");
        check_read(2, "R9");
        check_read(5, "R9");
        check_read(7, "R9");
    endtask

    task automatic t_clear_race();
        nib(1'b0, 4'h0);
        nib(1'b1, 4'h2);
        for (int i = 3; i >= 0; i--) nib(1'b1, 16'h0080 >> (i*4));
        nib(1'b1, 4'h9);
        nib(1'b1, 4'h9);
        @(negedge clk);
        lframe_n = 1'b1;
        lad      = 4'hF;
        clr      = 1'b1;             // coincides with the capture pulse
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        idle(3);
        check_count("R11");
        check_read(0, "R11");
    endtask

    initial begin
        model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_single();
        t_other_addr();
        t_cycle_type();
        t_abort();
        t_fill();
        t_reads_passive();
        t_clear();
        t_range();
        t_clear_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule